// File: doc/BRIEF.md
# Serial Shift Unit with Edge Counter and Start Detector

This block is a small serial engine for a controller that runs a serial protocol mostly in firmware. A shift register moves data MSB first, one bit for each shift event. A 4-bit counter counts clock events, and when it wraps the block reports that a transfer is complete. The shift and count events can come from three places: edges on the serial clock pin, a pulse from a timer compare, or a strobe from software. The wire mode picks one of these framings: off, three-wire (SPI-like) or two-wire (I2C-like). In two-wire mode a detector watches for a start condition on the bus. The block can also hold the clock line low, so that a remote master waits until software has dealt with the current event.

The received byte leaves the block as a stream. When the counter wraps, the value in the shift register is copied into a buffer register and `buf_valid` rises. A cycle with `buf_valid` and `buf_ready` both high consumes the byte and clears the flag. The serial side cannot be stopped, so a byte that is not consumed before the next wrap is overwritten. In the two-wire mode with overflow hold, the clock line is held low while `buf_valid` is high, and this is the back-pressure of that mode. The block also takes software loads of the shift register and presets of the counter, and it shows both values on its outputs.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset the following are all 0: the shift register, the counter, the buffer and its valid flag, the start flag, the clock hold and `do_out`.
- R2: The clock select uses these codes: 2'b00 = software strobe, 2'b01 = timer tick, 2'b10 = external clock with the rising edge as the sample edge, 2'b11 = external clock with the falling edge as the sample edge. When an external code is selected, the counter counts both edges of the synchronized `sck_in`, so 16 edges make one byte. A pin change takes effect three clock cycles after it is applied.
- R3: With an external code, each sample edge shifts the synchronized `sda_in` into bit 0 while the bits move toward bit 7 (MSB first). The opposite edge does not shift.
- R4: With an external code, `do_out` takes bit 7 of the shift register at every non-sampling edge, and it takes bit 7 of the loaded value on a load. With codes 2'b00 and 2'b01, `do_out` equals bit 7 of the shift register.
- R5: With code 2'b00 each `sw_strobe` cycle shifts once and counts once. With code 2'b01 each `timer_tick` cycle does the same. The strobe that is not selected has no effect.
- R6: When the counter wraps from 15 to 0, the new shift register value is written into `buf_data` and `buf_valid` rises. `buf_valid` with `buf_ready` clears the flag, but a wrap in the same cycle wins.
- R7: `load_en` writes `load_data` into the shift register and overrides a shift in the same cycle, while the counter still counts that event. `cnt_load` presets the counter, overrides a count and suppresses the wrap.
- R8: The wire mode uses these codes: 2'b00 = off, 2'b01 = three-wire, 2'b10 = two-wire, 2'b11 = two-wire with overflow hold. The start flag is set only in the two-wire codes, when the synchronized `sda_in` falls while the synchronized `sck_in` is high. `start_clr` clears the flag, and a new start in the same cycle wins.
- R9: In the two-wire codes, `sck_hold` is high while the start flag is set. In code 2'b11 it is also high while `buf_valid` is set. In all other codes it is 0.
- R10: With wire mode 2'b00 there is no shift and no count from any source.
- R11: In the two-wire codes, `sda_pull_low` is the inverse of `do_out`. In the other codes it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wire_mode | input | 2 | Framing: off, three-wire, two-wire, two-wire with overflow hold |
| clk_sel | input | 2 | Source of shift and count events |
| sck_in | input | 1 | Serial clock pin level |
| sda_in | input | 1 | Serial data pin level |
| timer_tick | input | 1 | One-cycle timer compare pulse |
| sw_strobe | input | 1 | One-cycle software clock strobe |
| load_en | input | 1 | Write `load_data` into the shift register |
| load_data | input | 8 | Value for the shift register |
| cnt_load | input | 1 | Preset the counter |
| cnt_value | input | 4 | Counter preset value |
| start_clr | input | 1 | Clear the start flag |
| buf_ready | input | 1 | Consumer accepts the buffered byte |
| buf_valid | output | 1 | Buffered byte available (transfer complete) |
| buf_data | output | 8 | Byte captured at the counter wrap |
| start_flag | output | 1 | Start condition seen |
| sck_hold | output | 1 | Drive the clock line low |
| do_out | output | 1 | Serial data output |
| sda_pull_low | output | 1 | Pull the data line low (two-wire) |
| sr_data | output | 8 | Current shift register |
| cnt_q | output | 4 | Current counter value |

## Verification
A change on `sck_in` or `sda_in` goes through two synchronizer flops and an edge register, so the shift, count, start flag, hold and `do_out` change at the third rising edge after the pin changes. The bench holds each pin level for four cycles before it samples. Strobes, ticks, loads, presets and `buf_ready` act at the first edge and are checked one cycle later. A wrap sets `buf_valid` and copies the buffer in the same cycle as the last count. Every sample is taken one time unit after a rising edge.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef enum logic [1:0] {
    WM_OFF      = 2'b00,
    WM_THREE    = 2'b01,
    WM_TWO      = 2'b10,
    WM_TWO_HOLD = 2'b11
  } wire_mode_e;

  typedef enum logic [1:0] {
    CS_SOFT     = 2'b00,
    CS_TIMER    = 2'b01,
    CS_EXT_RISE = 2'b10,
    CS_EXT_FALL = 2'b11
  } clk_src_e;
endpackage

// File: rtl/sss_pin_sync.sv
module sss_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic prev
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign level = chain[STAGES-1];
  assign prev  = chain[STAGES];
endmodule

// File: rtl/sss_edge_counter.sv
module sss_edge_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count + ONE;
  end

  assign wrap = step && !load && (count == '1);

  // R7: no preset and no event leaves the count alone
  p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> count == $past(count));
  // R2: each event advances the count by one
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> count == $past(count) + ONE);
endmodule

// File: rtl/sss_start_det.sv
module sss_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_lvl,
  input  logic sda_fall,
  input  logic clr,
  output logic flag
);
  logic hit;
  assign hit = en && scl_lvl && sda_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R8: the flag only rises after a data fall with the clock high in two-wire
  p_start_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(en && scl_lvl && sda_fall));
  // R8: clearing without a new start drops the flag
  p_start_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wire_mode,
  input  logic [1:0]        clk_sel,
  input  logic              sck_in,
  input  logic              sda_in,
  input  logic              timer_tick,
  input  logic              sw_strobe,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              start_clr,
  input  logic              buf_ready,
  output logic              buf_valid,
  output logic [DATA_W-1:0] buf_data,
  output logic              start_flag,
  output logic              sck_hold,
  output logic              do_out,
  output logic              sda_pull_low,
  output logic [DATA_W-1:0] sr_data,
  output logic [CNT_W-1:0]  cnt_q
);
  import sss_pkg::*;

  localparam int MSB = DATA_W - 1;

  wire_mode_e wm;
  clk_src_e   cs;
  assign wm = wire_mode_e'(wire_mode);
  assign cs = clk_src_e'(clk_sel);

  // Pin synchronizers
  logic sck_lvl, sck_prev, sda_lvl, sda_prev;

  sss_pin_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .pin(sck_in), .level(sck_lvl), .prev(sck_prev));
  sss_pin_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .pin(sda_in), .level(sda_lvl), .prev(sda_prev));

  logic sck_rise, sck_fall, sda_fall;
  assign sck_rise = sck_lvl && !sck_prev;
  assign sck_fall = !sck_lvl && sck_prev;
  assign sda_fall = !sda_lvl && sda_prev;

  // Event selection
  logic active, two_wire, ext_src;
  logic samp_edge, out_edge, int_evt;
  logic shift_evt, count_evt, out_evt;

  assign active    = (wm != WM_OFF);
  assign two_wire  = (wm == WM_TWO) || (wm == WM_TWO_HOLD);
  assign ext_src   = (cs == CS_EXT_RISE) || (cs == CS_EXT_FALL);
  assign samp_edge = (cs == CS_EXT_RISE) ? sck_rise : sck_fall;
  assign out_edge  = (cs == CS_EXT_RISE) ? sck_fall : sck_rise;
  assign int_evt   = (cs == CS_SOFT) ? sw_strobe : timer_tick;

  assign shift_evt = active && (ext_src ? samp_edge : int_evt);
  assign count_evt = active && (ext_src ? (sck_rise || sck_fall) : int_evt);
  assign out_evt   = active && ext_src && out_edge;

  // Shift register and output latch
  logic [MSB:0] sr_q, sr_nxt;
  logic         do_q;

  always_comb begin
    sr_nxt = sr_q;
    if (load_en)        sr_nxt = load_data;
    else if (shift_evt) sr_nxt = {sr_q[MSB-1:0], sda_lvl};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      do_q <= 1'b0;
    end else begin
      sr_q <= sr_nxt;
      if (load_en)      do_q <= load_data[MSB];
      else if (out_evt) do_q <= sr_q[MSB];
    end
  end

  // Counter
  logic wrap;
  sss_edge_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_value),
    .step(count_evt), .count(cnt_q), .wrap(wrap));

  // Receive buffer stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_data  <= '0;
    end else if (wrap) begin
      buf_valid <= 1'b1;
      buf_data  <= sr_nxt;
    end else if (buf_valid && buf_ready) begin
      buf_valid <= 1'b0;
    end
  end

  // Start detector
  sss_start_det u_start (
    .clk(clk), .rst_n(rst_n), .en(two_wire), .scl_lvl(sck_lvl),
    .sda_fall(sda_fall), .clr(start_clr), .flag(start_flag));

  assign sck_hold     = (two_wire && start_flag) || ((wm == WM_TWO_HOLD) && buf_valid);
  assign do_out       = ext_src ? do_q : sr_q[MSB];
  assign sda_pull_low = two_wire && !do_out;
  assign sr_data      = sr_q;

  // R9: the clock line is never held outside the two-wire codes
  p_hold_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sck_hold |-> wire_mode[1]);
  // R6: a new buffered byte coincides with the counter wrapping to zero
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_valid) |-> cnt_q == '0);
  // R10: a disabled unit never moves its counter unless preset
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wire_mode == 2'b00 && !cnt_load) |=> $stable(cnt_q));
  // R7: without load or shift event the shift register holds
  p_sr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !shift_evt) |=> $stable(sr_data));
  // R6: an unconsumed byte stays intact until the next wrap
  p_buf_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !buf_ready && !wrap) |=> (buf_valid && $stable(buf_data)));
endmodule

// File: tb/sim_serial_shift_unit.sv
`timescale 1ns/1ps
module sim_serial_shift_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] wire_mode = 2'b00, clk_sel = 2'b00;
  logic       sck_in = 1'b0, sda_in = 1'b0, timer_tick = 1'b0, sw_strobe = 1'b0;
  logic       load_en = 1'b0, cnt_load = 1'b0, start_clr = 1'b0, buf_ready = 1'b0;
  logic [7:0] load_data = 8'h00;
  logic [3:0] cnt_value = 4'h0;
  logic       buf_valid, start_flag, sck_hold, do_out, sda_pull_low;
  logic [7:0] buf_data, sr_data;
  logic [3:0] cnt_q;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  serial_shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .wire_mode(wire_mode), .clk_sel(clk_sel),
    .sck_in(sck_in), .sda_in(sda_in), .timer_tick(timer_tick), .sw_strobe(sw_strobe),
    .load_en(load_en), .load_data(load_data), .cnt_load(cnt_load), .cnt_value(cnt_value),
    .start_clr(start_clr), .buf_ready(buf_ready), .buf_valid(buf_valid), .buf_data(buf_data),
    .start_flag(start_flag), .sck_hold(sck_hold), .do_out(do_out),
    .sda_pull_low(sda_pull_low), .sr_data(sr_data), .cnt_q(cnt_q));

  function automatic logic [7:0] shift_in(logic [7:0] v, logic b);
    return {v[6:0], b};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_strobe();
    sw_strobe = 1'b1; tick(1); sw_strobe = 1'b0;
  endtask

  task automatic pulse_timer();
    timer_tick = 1'b1; tick(1); timer_tick = 1'b0;
  endtask

  task automatic preset(logic [3:0] c, logic [7:0] d);
    cnt_load = 1'b1; cnt_value = c; load_en = 1'b1; load_data = d;
    tick(1);
    cnt_load = 1'b0; load_en = 1'b0;
  endtask

  task automatic consume();
    buf_ready = 1'b1; tick(1); buf_ready = 1'b0;
  endtask

  // One byte with the external clock; fall_sample selects code 2'b11
  task automatic ext_byte(logic fall_sample, logic [7:0] tx, logic [7:0] rx);
    wire_mode = 2'b00;
    sck_in = fall_sample;
    tick(5);
    clk_sel = fall_sample ? 2'b11 : 2'b10;
    preset(4'h0, tx);
    wire_mode = 2'b01;
    for (int i = 7; i >= 0; i--) begin
      chk("R4 do_out before sample edge", do_out, tx[i]);
      sda_in = rx[i];
      tick(4);
      sck_in = ~sck_in;
      tick(4);
      if (i == 7) chk("R2 count after first edge", cnt_q, 4'd1);
      sck_in = ~sck_in;
      tick(4);
    end
    chk("R2 counter wrapped after 16 edges", cnt_q, 4'd0);
    chk("R3 MSB-first receive", sr_data, rx);
    chk("R6 buffer valid", buf_valid, 1'b1);
    chk("R6 buffer data", buf_data, rx);
    consume();
    chk("R6 handshake clears valid", buf_valid, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] exp_sr;
    logic [7:0] a;
    logic [3:0] c0;
    void'($urandom(32'd4242));
    tick(3);
    // R1 reset state
    chk("R1 shift register", sr_data, 8'h00);
    chk("R1 counter", cnt_q, 4'h0);
    chk("R1 buffer", {buf_valid, buf_data}, 9'h000);
    chk("R1 start/hold", {start_flag, sck_hold}, 2'b00);
    chk("R1 do_out", do_out, 1'b0);
    rst_n = 1'b1;
    tick(2);

    // R2/R3/R4/R6: directed patterns, then random bytes, both sample polarities
    ext_byte(1'b0, 8'hA5, 8'h3C);
    ext_byte(1'b1, 8'h00, 8'hFF);
    for (int k = 0; k < 6; k++)
      ext_byte(k[0], 8'($urandom), 8'($urandom));

    // R10: disabled mode ignores clock edges and strobes
    wire_mode = 2'b00; clk_sel = 2'b10;
    c0 = cnt_q; a = sr_data;
    for (int k = 0; k < 4; k++) begin sck_in = ~sck_in; tick(4); end
    clk_sel = 2'b00; pulse_strobe();
    chk("R10 counter frozen when off", cnt_q, c0);
    chk("R10 shift register frozen when off", sr_data, a);

    // R5/R4: software strobe, counter preset to 8 so eight strobes wrap
    wire_mode = 2'b01; clk_sel = 2'b00;
    exp_sr = 8'($urandom);
    preset(4'd8, exp_sr);
    for (int k = 0; k < 8; k++) begin
      logic b;
      b = 1'($urandom);
      sda_in = b; tick(4);
      pulse_strobe();
      exp_sr = shift_in(exp_sr, b);
      chk("R4 do_out follows bit 7 (software)", do_out, exp_sr[7]);
      chk("R5 software strobe shifts", sr_data, exp_sr);
    end
    chk("R6 wrap from preset sets valid", buf_valid, 1'b1);
    chk("R6 wrap copies shift value", buf_data, exp_sr);
    consume();
    c0 = cnt_q;
    pulse_timer();
    chk("R5 timer tick ignored in software mode", {cnt_q, sr_data}, {c0, exp_sr});

    // R5: timer tick source
    clk_sel = 2'b01;
    sda_in = 1'b1; tick(4);
    for (int k = 0; k < 3; k++) begin
      pulse_timer();
      exp_sr = shift_in(exp_sr, 1'b1);
    end
    chk("R5 timer ticks shift", sr_data, exp_sr);
    chk("R5 timer ticks count", cnt_q, c0 + 4'd3);
    pulse_strobe();
    chk("R5 strobe ignored in timer mode", {cnt_q, sr_data}, {c0 + 4'd3, exp_sr});

    // R7: load beats shift but the event still counts; preset beats count
    clk_sel = 2'b00;
    c0 = cnt_q;
    load_en = 1'b1; load_data = 8'h5A; sw_strobe = 1'b1;
    tick(1);
    load_en = 1'b0; sw_strobe = 1'b0;
    chk("R7 load overrides shift", sr_data, 8'h5A);
    chk("R7 event still counted", cnt_q, c0 + 4'd1);
    cnt_load = 1'b1; cnt_value = 4'd15; sw_strobe = 1'b1;
    tick(1);
    cnt_load = 1'b0; sw_strobe = 1'b0;
    chk("R7 preset overrides count, no wrap", {cnt_q, buf_valid}, {4'd15, 1'b0});

    // R6: wrap and consume in the same cycle, wrap wins
    preset(4'd15, 8'h81);
    pulse_strobe();
    chk("R6 first wrap", buf_valid, 1'b1);
    preset(4'd15, 8'h42);
    sda_in = 1'b0; tick(4);
    buf_ready = 1'b1; sw_strobe = 1'b1;
    tick(1);
    buf_ready = 1'b0; sw_strobe = 1'b0;
    chk("R6 wrap wins over consume", {buf_valid, buf_data}, {1'b1, 8'h84});
    consume();

    // R8/R9: start detection in two-wire mode
    wire_mode = 2'b10; clk_sel = 2'b00;
    sck_in = 1'b1; sda_in = 1'b1; tick(5);
    chk("R8 no start before fall", start_flag, 1'b0);
    sda_in = 1'b0; tick(4);
    chk("R8 start on data fall with clock high", start_flag, 1'b1);
    chk("R9 hold while start flag set", sck_hold, 1'b1);
    start_clr = 1'b1; tick(1); start_clr = 1'b0;
    chk("R8 clear drops start flag", {start_flag, sck_hold}, 2'b00);
    sck_in = 1'b0; tick(4); sda_in = 1'b1; tick(4); sda_in = 1'b0; tick(4);
    chk("R8 data fall with clock low ignored", start_flag, 1'b0);
    wire_mode = 2'b01;
    sda_in = 1'b1; tick(4); sck_in = 1'b1; tick(4); sda_in = 1'b0; tick(4);
    chk("R8 no start in three-wire", start_flag, 1'b0);
    chk("R9 no hold in three-wire", sck_hold, 1'b0);

    // R9: overflow hold only in code 2'b11
    wire_mode = 2'b11;
    preset(4'd15, 8'h00);
    pulse_strobe();
    chk("R9 overflow holds clock in hold mode", {buf_valid, sck_hold}, 2'b11);
    consume();
    chk("R9 consume releases hold", sck_hold, 1'b0);
    wire_mode = 2'b10;
    preset(4'd15, 8'h00);
    pulse_strobe();
    chk("R9 no overflow hold in plain two-wire", {buf_valid, sck_hold}, 2'b10);
    consume();

    // R11: open-drain data pull
    preset(4'd0, 8'h00);
    chk("R11 pull low when bit 7 is 0", sda_pull_low, 1'b1);
    preset(4'd0, 8'h80);
    chk("R11 release when bit 7 is 1", sda_pull_low, 1'b0);
    wire_mode = 2'b01;
    preset(4'd0, 8'h00);
    chk("R11 no pull in three-wire", sda_pull_low, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule